// File: doc/BRIEF.md
# Infrared pulse width capture receiver

This block turns one infrared input into a stream of timed level records. A programmable divider derives a sampling tick from the system clock, and a glitch filter cleans the raw input before it is sampled. While a reception runs, the block counts how many sampling ticks each high or low level lasts. Whenever the filtered level changes, it emits one 32-bit record that holds the finished level and its length. A downstream FIFO, not part of this block, takes the records.

A reception is armed by a run-enable. It then starts either on a chosen input edge or on a one-cycle software pulse. It ends when a chosen level lasts at least a programmable number of ticks: a threshold event fires and the block holds until the run-enable is dropped. If the duration counter runs out before that happens, an overflow event ends the reception instead. With a demodulating receiver module in front, the records are baseband symbols. With a bare photodiode, they are individual carrier half-periods.

Top module: `ir_pw_capture`

## Requirements
- R1: A sampling tick occurs once every DIV+1 system clock cycles, with DIV = `div_i`. All durations are counted in ticks, so a level held for k*(DIV+1) cycles is reported as k.
- R2: When the filtered level changes during a reception, `rec_valid_o` pulses for one cycle. At the same time `rec_data_o` carries bit 31 = the finished level (1 high, 0 low) and bits 30:0 = its length in ticks, which is never zero. At most one of `rec_valid_o`, `thr_evt_o` and `ovf_evt_o` is high in any cycle.
- R3: With `auto_start_i` = 1, reception starts on the first sampled edge that matches `trig_sel_i`. Code 00 matches a falling edge, 01 a rising edge and 10 either edge. Code 11 never starts a reception. Edges of the other kind are ignored.
- R4: With `auto_start_i` = 0, input edges do not start a reception. A one-cycle `sw_start_i` pulse starts one at the next sampling tick, and the first level is measured from that tick. With `auto_start_i` = 1, `sw_start_i` has no effect.
- R5: A threshold event is raised only for the level selected by `end_level_i` (0 low, 1 high). When the count of that level reaches `thresh_i`, `thr_evt_o` pulses, `busy_o` falls and the level is not reported. The other level may exceed the threshold without ending the reception. The threshold pulse comes `thresh_i`-1 cycles after the record that began the watched level, when DIV = 0.
- R6: If the duration counter is at its maximum and must advance while no threshold event applies, `ovf_evt_o` pulses and the reception ends.
- R7: The glitch filter accepts a new input level only after the input has differed from the current filtered level for N+1 consecutive system clocks, where N = `stage_i` * FILT_STEP. Shorter pulses do not change any reported duration.
- R8: After reset, and in the cycle after `run_i` goes low, the block is idle: `busy_o` is 0, the counter is cleared and no record is emitted for the interrupted level. `busy_o` is 1 exactly while a reception is measuring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Run-enable; low forces idle |
| div_i | input | 12 | Sampling divider, tick every div_i+1 clocks |
| stage_i | input | 3 | Glitch filter stage code |
| auto_start_i | input | 1 | 1 = edge-triggered start, 0 = software start |
| trig_sel_i | input | 2 | Start edge: 00 fall, 01 rise, 10 either |
| sw_start_i | input | 1 | One-cycle software start pulse |
| end_level_i | input | 1 | Level watched for termination |
| thresh_i | input | 31 | Termination threshold in ticks |
| ir_i | input | 1 | Infrared input, synchronous to clk_i |
| rec_valid_o | output | 1 | Record push strobe |
| rec_data_o | output | 32 | Record: level in bit 31, ticks in 30:0 |
| busy_o | output | 1 | Reception in progress |
| thr_evt_o | output | 1 | Threshold reached, reception ended |
| ovf_evt_o | output | 1 | Duration counter overflow, reception ended |

## Verification
The hardest case to reach is counter overflow: with the full 31-bit counter it takes billions of ticks. A second instance built with a 4-bit counter shares the main stimulus, so one level held for 30 cycles drives it past its limit while the main instance keeps measuring. Start-edge selection that skips the first edge and glitches one cycle shorter than the filter window are set up with directed sequences. Random frames vary the divider, the filter stage, the trigger code and the idle level.

// File: rtl/ir_cap_pkg.sv
package ir_cap_pkg;
  typedef enum logic [1:0] {RX_IDLE, RX_ARMED, RX_MEAS, RX_DONE} rx_state_e;
  localparam logic [1:0] TRIG_FALL = 2'b00;
  localparam logic [1:0] TRIG_RISE = 2'b01;
  localparam logic [1:0] TRIG_ANY  = 2'b10;
  localparam int DUR_W = 31;
  localparam int REC_W = DUR_W + 1;
endpackage

// File: rtl/ir_samp_div.sv
module ir_samp_div #(
  parameter int DIV_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  // >= so a divider lowered mid-count wraps at once
  assign tick_o = en_i && (cnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!en_i || tick_o)  cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  assert_tick_spacing_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div_i != '0) |=> (!tick_o || !$stable(div_i)));
endmodule

// File: rtl/ir_glitch_filt.sv
module ir_glitch_filt #(
  parameter int   STG_W     = 3,
  parameter int   FILT_STEP = 1,
  parameter logic IDLE_LVL  = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [STG_W-1:0] stage_i,
  input  logic             in_i,
  output logic             lvl_o
);
  localparam int NMAX = ((1 << STG_W) - 1) * FILT_STEP;
  localparam int CW   = $clog2(NMAX + 2);

  logic [CW-1:0] lim;
  logic [CW-1:0] run_q;
  logic          lvl_q;

  assign lim   = CW'(stage_i) * CW'(FILT_STEP);
  assign lvl_o = lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= IDLE_LVL;
      run_q <= '0;
    end else if (in_i == lvl_q) begin
      run_q <= '0;
    end else if (run_q >= lim) begin
      lvl_q <= in_i;
      run_q <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  assert_filt_follows_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_q != $past(lvl_q)) |-> ($past(in_i) == lvl_q));
  assert_filt_two_cycles_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((lvl_q != $past(lvl_q)) && ($past(lim) != '0)) |-> ($past(in_i, 2) == lvl_q));
endmodule

// File: rtl/ir_level_meter.sv
module ir_level_meter import ir_cap_pkg::*; #(
  parameter int CNT_W = 31
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             lvl_i,
  input  logic             auto_i,
  input  logic [1:0]       trig_i,
  input  logic             sw_start_i,
  input  logic             end_lvl_i,
  input  logic [DUR_W-1:0] thresh_i,
  output logic             rec_valid_o,
  output logic [REC_W-1:0] rec_data_o,
  output logic             busy_o,
  output logic             thr_o,
  output logic             ovf_o
);
  rx_state_e        state_q;
  logic             prev_q, cur_q, pend_q;
  logic [CNT_W-1:0] cnt_q;
  logic             hit, man_req, start;
  logic [DUR_W:0]   nxt;

  always_comb begin
    unique case (trig_i)
      TRIG_FALL: hit = prev_q & ~lvl_i;
      TRIG_RISE: hit = ~prev_q & lvl_i;
      TRIG_ANY:  hit = prev_q ^ lvl_i;
      default:   hit = 1'b0;
    endcase
  end

  assign man_req = !auto_i && sw_start_i;
  assign start   = tick_i && (auto_i ? hit : (pend_q || man_req));
  assign nxt     = (DUR_W + 1)'(cnt_q) + 1'b1;
  assign busy_o  = (state_q == RX_MEAS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= RX_IDLE;
      prev_q      <= 1'b0;
      cur_q       <= 1'b0;
      pend_q      <= 1'b0;
      cnt_q       <= '0;
      rec_valid_o <= 1'b0;
      rec_data_o  <= '0;
      thr_o       <= 1'b0;
      ovf_o       <= 1'b0;
    end else begin
      rec_valid_o <= 1'b0;
      thr_o       <= 1'b0;
      ovf_o       <= 1'b0;
      // edge history only advances on ticks, tracks freely while stopped
      if (!run_i || tick_i) prev_q <= lvl_i;
      if (!run_i) begin
        state_q <= RX_IDLE;
        cnt_q   <= '0;
        pend_q  <= 1'b0;
      end else begin
        unique case (state_q)
          RX_IDLE: state_q <= RX_ARMED;
          RX_ARMED: begin
            if (start) begin
              state_q <= RX_MEAS;
              cur_q   <= lvl_i;
              cnt_q   <= CNT_W'(1);
              pend_q  <= 1'b0;
            end else if (man_req) begin
              pend_q  <= 1'b1;
            end
          end
          RX_MEAS: begin
            if (tick_i) begin
              if (lvl_i != cur_q) begin
                rec_valid_o <= 1'b1;
                rec_data_o  <= {cur_q, DUR_W'(cnt_q)};
                cur_q       <= lvl_i;
                cnt_q       <= CNT_W'(1);
              end else if (cur_q == end_lvl_i && nxt >= {1'b0, thresh_i}) begin
                thr_o   <= 1'b1;
                state_q <= RX_DONE;
              end else if (cnt_q == '1) begin
                ovf_o   <= 1'b1;
                state_q <= RX_DONE;
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_events_exclusive_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rec_valid_o, thr_o, ovf_o}));
  assert_rec_nonzero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |-> (rec_data_o[DUR_W-1:0] != '0));
  assert_start_on_tick_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(tick_i));
  assert_thr_ends_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_o |-> !busy_o);
  assert_ovf_ends_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> !busy_o);
  assert_run_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (!busy_o && !rec_valid_o));
endmodule

// File: rtl/ir_pw_capture.sv
module ir_pw_capture import ir_cap_pkg::*; #(
  parameter int   DIV_W     = 12,
  parameter int   STG_W     = 3,
  parameter int   FILT_STEP = 1,
  parameter int   CNT_W     = 31,
  parameter logic IDLE_LVL  = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [STG_W-1:0] stage_i,
  input  logic             auto_start_i,
  input  logic [1:0]       trig_sel_i,
  input  logic             sw_start_i,
  input  logic             end_level_i,
  input  logic [DUR_W-1:0] thresh_i,
  input  logic             ir_i,
  output logic             rec_valid_o,
  output logic [REC_W-1:0] rec_data_o,
  output logic             busy_o,
  output logic             thr_evt_o,
  output logic             ovf_evt_o
);
  logic tick, filt_lvl;

  ir_samp_div #(.DIV_W(DIV_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (run_i),
    .div_i  (div_i),
    .tick_o (tick)
  );

  ir_glitch_filt #(.STG_W(STG_W), .FILT_STEP(FILT_STEP), .IDLE_LVL(IDLE_LVL)) u_filt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .stage_i (stage_i),
    .in_i    (ir_i),
    .lvl_o   (filt_lvl)
  );

  ir_level_meter #(.CNT_W(CNT_W)) u_meter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run_i),
    .tick_i      (tick),
    .lvl_i       (filt_lvl),
    .auto_i      (auto_start_i),
    .trig_i      (trig_sel_i),
    .sw_start_i  (sw_start_i),
    .end_lvl_i   (end_level_i),
    .thresh_i    (thresh_i),
    .rec_valid_o (rec_valid_o),
    .rec_data_o  (rec_data_o),
    .busy_o      (busy_o),
    .thr_o       (thr_evt_o),
    .ovf_o       (ovf_evt_o)
  );
endmodule

// File: tb/sim_ir_pw_capture.sv
module sim_ir_pw_capture;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic [11:0] div = '0;
  logic [2:0]  stage = '0;
  logic        auto_st = 1'b1;
  logic [1:0]  trig = '0;
  logic        sw = 1'b0;
  logic        end_lvl = 1'b1;
  logic [30:0] thresh = 31'd40;
  logic        ir = 1'b1;

  logic        rec_valid, busy, thr_evt, ovf_evt;
  logic [31:0] rec_data;
  logic        rec_valid1, busy1, thr_evt1, ovf_evt1;
  logic [31:0] rec_data1;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0, rec_cyc = 0, thr_cyc = 0;
  int thr_n = 0, ovf_n = 0, thr1_n = 0, ovf1_n = 0;
  logic [31:0] rq[$];
  logic [31:0] exq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ir_pw_capture u0 (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .div_i(div), .stage_i(stage),
    .auto_start_i(auto_st), .trig_sel_i(trig), .sw_start_i(sw), .end_level_i(end_lvl),
    .thresh_i(thresh), .ir_i(ir), .rec_valid_o(rec_valid), .rec_data_o(rec_data),
    .busy_o(busy), .thr_evt_o(thr_evt), .ovf_evt_o(ovf_evt));

  ir_pw_capture #(.CNT_W(4)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .div_i(div), .stage_i(stage),
    .auto_start_i(auto_st), .trig_sel_i(trig), .sw_start_i(sw), .end_level_i(end_lvl),
    .thresh_i(thresh), .ir_i(ir), .rec_valid_o(rec_valid1), .rec_data_o(rec_data1),
    .busy_o(busy1), .thr_evt_o(thr_evt1), .ovf_evt_o(ovf_evt1));

  always @(negedge clk) begin
    cyc++;
    if (rec_valid) begin rq.push_back(rec_data); rec_cyc = cyc; end
    if (thr_evt) begin thr_n++; thr_cyc = cyc; end
    if (ovf_evt) ovf_n++;
    if (thr_evt1) thr1_n++;
    if (ovf_evt1) ovf1_n++;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic hold(input bit lvl, input int cycles);
    ir = lvl;
    repeat (cycles) @(negedge clk);
  endtask

  task automatic setup(input int d, input int st, input int tg, input bit idle,
                       input bit au, input bit el, input int th);
    run = 1'b0; div = 12'(d); stage = 3'(st); trig = 2'(tg); auto_st = au;
    end_lvl = el; thresh = 31'(th); ir = idle; sw = 1'b0;
    repeat (st + 6) @(negedge clk);
    run = 1'b1;
    repeat (2 * (d + 1) + 3) @(negedge clk);
    rq.delete(); exq.delete();
    thr_n = 0; ovf_n = 0; thr1_n = 0; ovf1_n = 0;
  endtask

  task automatic compare(input string tag);
    chk(rq.size() == exq.size(), tag, 32'(rq.size()), 32'(exq.size()));
    for (int i = 0; i < rq.size() && i < exq.size(); i++)
      chk(rq[i] == exq[i], tag, rq[i], exq[i]);
  endtask

  task automatic rand_frame();
    int d  = $urandom % 4;
    int st = $urandom % 4;
    int tg = $urandom % 3;
    bit f  = 1'($urandom % 2);
    int n  = 3 + $urandom % 5;
    int s;
    bit lv;
    string tag;
    // first edge is idle->f; it starts the frame only if the code matches it
    s = (tg == 2 || (tg == 0 && !f) || (tg == 1 && f)) ? 0 : 1;
    tag = (d > 0) ? "R1" : ((s == 1) ? "R3" : "R2");
    setup(d, st, tg, !f, 1'b1, f ^ 1'((n - 1) % 2), 40);
    for (int i = 0; i < n - 1; i++) begin
      int k = st + 2 + $urandom % 12;
      lv = f ^ 1'(i % 2);
      if (i >= s) exq.push_back({lv, 31'(k)});
      hold(lv, k * (d + 1));
    end
    hold(f ^ 1'((n - 1) % 2), 46 * (d + 1) + st + 6);
    compare(tag);
    chk(thr_n == 1, "R5", 32'(thr_n), 32'd1);
    chk(!busy, "R5", 32'(busy), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog (all requirements) act=timeout exp=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk(!busy && !rec_valid && !thr_evt && !ovf_evt, "R8 reset", {busy, rec_valid, thr_evt, ovf_evt}, 0);

    // R1 directed: div 2, falling trigger
    setup(2, 0, 0, 1'b1, 1'b1, 1'b1, 40);
    hold(0, 5 * 3); hold(1, 7 * 3); hold(0, 9 * 3); hold(1, 50 * 3);
    exq.push_back({1'b0, 31'd5}); exq.push_back({1'b1, 31'd7}); exq.push_back({1'b0, 31'd9});
    compare("R1");

    // R3 rising trigger skips first (falling) edge
    setup(0, 0, 1, 1'b1, 1'b1, 1'b0, 40);
    hold(0, 6); hold(1, 11); hold(0, 60);
    exq.push_back({1'b1, 31'd11});
    compare("R3");
    // R3 code 11 never starts
    setup(0, 0, 3, 1'b1, 1'b1, 1'b0, 40);
    hold(0, 6); hold(1, 6); hold(0, 6);
    chk(!busy && rq.size() == 0, "R3 code11", {busy, 31'(rq.size())}, 0);

    // R4 software start ignored in auto mode
    setup(0, 0, 1, 1'b0, 1'b1, 1'b1, 30);
    sw = 1'b1; @(negedge clk); sw = 1'b0;
    hold(0, 10);
    chk(!busy && rq.size() == 0, "R4 auto ignores sw", {busy, 31'(rq.size())}, 0);

    // R4 manual: edges ignored, pulse starts, R5 exact threshold timing
    setup(0, 0, 0, 1'b0, 1'b0, 1'b1, 30);
    hold(1, 5); hold(0, 5);
    chk(!busy && rq.size() == 0, "R4 manual ignores edges", {busy, 31'(rq.size())}, 0);
    sw = 1'b1; @(negedge clk); sw = 1'b0;
    repeat (9) @(negedge clk);
    hold(1, 40);
    exq.push_back({1'b0, 31'd11});
    compare("R4");
    chk(thr_n == 1, "R5", 32'(thr_n), 32'd1);
    chk(thr_cyc - rec_cyc == 29, "R5 timing", 32'(thr_cyc - rec_cyc), 32'd29);

    // R5 unwatched level may exceed threshold
    setup(0, 0, 0, 1'b1, 1'b1, 1'b1, 10);
    hold(0, 30);
    chk(busy && thr_n == 0, "R5 unwatched", {busy, 31'(thr_n)}, 32'h8000_0000);
    hold(1, 25);
    exq.push_back({1'b0, 31'd30});
    compare("R5");
    chk(thr_n == 1, "R5", 32'(thr_n), 32'd1);
    chk(thr_cyc - rec_cyc == 9, "R5 timing", 32'(thr_cyc - rec_cyc), 32'd9);

    // R7 glitch of N cycles rejected (stage 3)
    setup(0, 3, 0, 1'b1, 1'b1, 1'b0, 40);
    hold(0, 8); hold(1, 3); hold(0, 9); hold(1, 15); hold(0, 60);
    exq.push_back({1'b0, 31'd20}); exq.push_back({1'b1, 31'd15});
    compare("R7 reject");
    // R7 pulse of N+1 cycles accepted
    setup(0, 3, 0, 1'b1, 1'b1, 1'b0, 40);
    hold(0, 6); hold(1, 4); hold(0, 10); hold(1, 12); hold(0, 60);
    exq.push_back({1'b0, 31'd6}); exq.push_back({1'b1, 31'd4});
    exq.push_back({1'b0, 31'd10}); exq.push_back({1'b1, 31'd12});
    compare("R7 accept");

    // R8 run clear mid-level, then fresh frame
    setup(1, 0, 0, 1'b1, 1'b1, 1'b1, 40);
    hold(0, 10);
    chk(busy, "R8 busy", 32'(busy), 32'd1);
    run = 1'b0; @(negedge clk);
    chk(!busy, "R8 clear", 32'(busy), 32'd0);
    repeat (5) @(negedge clk);
    chk(rq.size() == 0 && thr_n == 0, "R8 no record", 32'(rq.size()), 32'd0);
    run = 1'b1; repeat (5) @(negedge clk);
    hold(1, 12); hold(0, 16); hold(1, 120);
    exq.push_back({1'b0, 31'd8});
    compare("R8 restart");

    // R6 overflow on narrow-counter instance
    setup(0, 0, 0, 1'b1, 1'b1, 1'b1, 1000);
    hold(0, 30);
    chk(ovf1_n == 1 && thr1_n == 0, "R6 ovf", {ovf1_n[15:0], thr1_n[15:0]}, 32'h0001_0000);
    chk(!busy1, "R6 ends", 32'(busy1), 32'd0);
    chk(busy && ovf_n == 0, "R6 wide no ovf", {busy, 31'(ovf_n)}, 32'h8000_0000);

    // random frames
    for (int r = 0; r < 15; r++) rand_frame();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule